// File: doc/BRIEF.md
# Microcomputer Bus Decoder and Peripheral Glue

This block sits between an 8-bit CPU and its memories and peripherals. It takes a 16-bit address bus and the read and write enables, and it decodes them into chip selects for program RAM, a 256-byte scratch RAM, program ROM and a multiplexed key input port. It also produces a select code for the read-data multiplexer. That code points at all-ones whenever the address belongs to a strobe-only location or to no device at all.

Three fixed addresses have side effects in the block itself. A read of the speaker location toggles a one-bit speaker flip-flop. A read of the interrupt-clear location emits a one-cycle clear pulse. A write to the display location fans three alternate data bits out to three serial LCD column drivers and then gives them one shared shift-clock pulse. A read side effect happens once per bus read cycle, when the read enable rises, and not once per clock while the enable stays high.

Top module: `mcu_bus_glue`

## Requirements
- R1: Addresses 0x0000 to 0x3FFF assert `main_ram_cs_o` only, and `rd_sel_o` equals 1.
- R2: Addresses 0x5000 to 0x50FF assert `scratch_cs_o` only, and `rd_sel_o` equals 2.
- R3: Addresses 0x8000 to 0xFFFF assert `rom_cs_o` only, and `rd_sel_o` equals 3.
- R4: Addresses 0x4000 to 0x407F assert `key_cs_o` only, and `rd_sel_o` equals 4. `key_row_o` carries address bits 5..0 and `cfg_sel_o` is high when address bit 6 is 0. When the key port is not selected, both are 0.
- R5: At most one chip select is active at any time. Unmapped addresses assert none of them, and `rd_sel_o` equals 0 (all-ones data).
- R6: The strobe addresses 0x4400, 0x4800 and 0x4C00 assert no chip select, and `rd_sel_o` equals 0.
- R7: `spk_o` resets to 0. It inverts one cycle after the read enable rises on 0x4800, and it inverts only once per read cycle however long the enable stays high.
- R8: A read cycle that starts on 0x4C00 drives `irq_clr_o` high for exactly one cycle, one cycle after the read enable rises.
- R9: A write cycle on 0x4400 loads data bits 0, 2 and 4 onto `lcd_data_o` bits 0, 1 and 2, one cycle after the write enable rises. The lines then hold until the next such write.
- R10: `lcd_clk_o` goes high for exactly one cycle, in the cycle after `lcd_data_o` is updated. At all other times it is low.
- R11: The side effects are tied to their direction. A write to 0x4800 does not change `spk_o`, a write to 0x4C00 does not pulse `irq_clr_o`, and a read of 0x4400 changes neither `lcd_data_o` nor `lcd_clk_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU address bus |
| wdata_i | input | 8 | CPU write data |
| rd_i | input | 1 | Read enable |
| wr_i | input | 1 | Write enable |
| main_ram_cs_o | output | 1 | Program RAM select |
| scratch_cs_o | output | 1 | Scratch RAM select |
| rom_cs_o | output | 1 | ROM select |
| key_cs_o | output | 1 | Key input port select |
| key_row_o | output | 6 | Key row select from the address |
| cfg_sel_o | output | 1 | Configuration diode select |
| rd_sel_o | output | 3 | Read-data mux select: 0 ones, 1 main RAM, 2 scratch, 3 ROM, 4 keys |
| spk_o | output | 1 | Speaker flip-flop |
| lcd_data_o | output | 3 | Serial data, one line per LCD driver |
| lcd_clk_o | output | 1 | Shared LCD shift clock |
| irq_clr_o | output | 1 | Interrupt-clear pulse |

## Verification
The hardest behaviour to reach is the once-per-read-cycle rule. It only shows up when the read enable stays high for several clocks on the same strobe address, or when it drops for a single cycle between two reads. The stimulus holds a speaker read for three cycles and expects one inversion. It then pulses reads with one-cycle gaps and expects an inversion for each pulse. Interrupt-clear reads are stretched the same way. A read of the display address and writes to the speaker and interrupt-clear addresses are placed between these cycles to show that each direction leaves the other side effects untouched.

// File: rtl/mcu_bus_glue_pkg.sv
package mcu_bus_glue_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int NUM_LCD = 3;
  localparam int LCD_BIT_STRIDE = 2;
  localparam int KEY_ROW_W = 6;

  localparam logic [ADDR_W-1:0] MAIN_LO    = 16'h0000;
  localparam logic [ADDR_W-1:0] MAIN_HI    = 16'h3FFF;
  localparam logic [ADDR_W-1:0] KEY_LO     = 16'h4000;
  localparam logic [ADDR_W-1:0] KEY_HI     = 16'h407F;
  localparam logic [ADDR_W-1:0] SCR_LO     = 16'h5000;
  localparam logic [ADDR_W-1:0] SCR_HI     = 16'h50FF;
  localparam logic [ADDR_W-1:0] ROM_LO     = 16'h8000;
  localparam logic [ADDR_W-1:0] ROM_HI     = 16'hFFFF;
  localparam logic [ADDR_W-1:0] LCD_ADDR   = 16'h4400;
  localparam logic [ADDR_W-1:0] SPK_ADDR   = 16'h4800;
  localparam logic [ADDR_W-1:0] IRQC_ADDR  = 16'h4C00;

  typedef enum logic [2:0] {
    RSEL_ONES    = 3'd0,
    RSEL_MAIN    = 3'd1,
    RSEL_SCRATCH = 3'd2,
    RSEL_ROM     = 3'd3,
    RSEL_KEYS    = 3'd4
  } rd_sel_e;

  function automatic logic in_range(input logic [ADDR_W-1:0] a,
                                    input logic [ADDR_W-1:0] lo,
                                    input logic [ADDR_W-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction
endpackage

// File: rtl/mcu_bus_glue_decode.sv
module mcu_bus_glue_decode
  import mcu_bus_glue_pkg::*;
(
  input  logic [ADDR_W-1:0]    addr_i,
  output logic                 main_ram_cs_o,
  output logic                 scratch_cs_o,
  output logic                 rom_cs_o,
  output logic                 key_cs_o,
  output logic [KEY_ROW_W-1:0] key_row_o,
  output logic                 cfg_sel_o,
  output rd_sel_e              rd_sel_o,
  output logic                 hit_lcd_o,
  output logic                 hit_spk_o,
  output logic                 hit_irqc_o
);
  localparam int CFG_BIT = KEY_ROW_W;

  always_comb begin
    main_ram_cs_o = in_range(addr_i, MAIN_LO, MAIN_HI);
    scratch_cs_o  = in_range(addr_i, SCR_LO, SCR_HI);
    rom_cs_o      = in_range(addr_i, ROM_LO, ROM_HI);
    key_cs_o      = in_range(addr_i, KEY_LO, KEY_HI);
    hit_lcd_o     = (addr_i == LCD_ADDR);
    hit_spk_o     = (addr_i == SPK_ADDR);
    hit_irqc_o    = (addr_i == IRQC_ADDR);
    key_row_o     = key_cs_o ? addr_i[KEY_ROW_W-1:0] : '0;
    cfg_sel_o     = key_cs_o & ~addr_i[CFG_BIT];
  end

  always_comb begin
    rd_sel_o = RSEL_ONES;
    if (main_ram_cs_o)     rd_sel_o = RSEL_MAIN;
    else if (scratch_cs_o) rd_sel_o = RSEL_SCRATCH;
    else if (rom_cs_o)     rd_sel_o = RSEL_ROM;
    else if (key_cs_o)     rd_sel_o = RSEL_KEYS;
  end

  always_comb begin
    AST_CS_ONEHOT: assert ($onehot0({main_ram_cs_o, scratch_cs_o, rom_cs_o, key_cs_o})); // R5
    AST_STROBE_NO_CS: assert (!((hit_lcd_o | hit_spk_o | hit_irqc_o) &&
                                (main_ram_cs_o | scratch_cs_o | rom_cs_o | key_cs_o))); // R6
  end
endmodule

// File: rtl/mcu_bus_glue_rdfx.sv
module mcu_bus_glue_rdfx (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_i,
  input  logic hit_spk_i,
  input  logic hit_irqc_i,
  output logic spk_o,
  output logic irq_clr_o
);
  logic rd_q;
  logic rd_start;

  assign rd_start = rd_i & ~rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q      <= 1'b0;
      spk_o     <= 1'b0;
      irq_clr_o <= 1'b0;
    end else begin
      rd_q      <= rd_i;
      irq_clr_o <= rd_start & hit_irqc_i;
      if (rd_start && hit_spk_i) spk_o <= ~spk_o;
    end
  end

  // speaker only moves when a read cycle began on its address
  AST_SPK_ONLY_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spk_o != $past(spk_o)) |-> ($past(rd_i) && $past(hit_spk_i))); // R7
  AST_IRQC_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_clr_o |=> !irq_clr_o); // R8
  AST_IRQC_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_clr_o |-> ($past(rd_i) && $past(hit_irqc_i))); // R8
endmodule

// File: rtl/mcu_bus_glue_lcdfeed.sv
module mcu_bus_glue_lcdfeed #(
  parameter int NUM_LCD = 3,
  parameter int DATA_W = 8,
  parameter int STRIDE = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               hit_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [NUM_LCD-1:0] sdata_o,
  output logic               sclk_o
);
  localparam int TOP_BIT = STRIDE * (NUM_LCD - 1);

  logic wr_q;
  logic load;
  logic arm_q;
  logic [NUM_LCD-1:0] pick;

  assign load = wr_i & ~wr_q & hit_i;

  for (genvar g = 0; g < NUM_LCD; g++) begin : g_pick
    assign pick[g] = wdata_i[STRIDE*g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= 1'b0;
      arm_q   <= 1'b0;
      sclk_o  <= 1'b0;
      sdata_o <= '0;
    end else begin
      wr_q   <= wr_i;
      arm_q  <= load;
      sclk_o <= arm_q;
      if (load) sdata_o <= pick;
    end
  end

  initial begin
    AST_LCD_BITS_FIT: assert (TOP_BIT < DATA_W); // R9
  end

  AST_SCLK_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |=> !sclk_o); // R10
  AST_SCLK_DATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(sdata_o)); // R10
  AST_DATA_ONLY_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdata_o) |-> ($past(wr_i) && $past(hit_i))); // R9
endmodule

// File: rtl/mcu_bus_glue.sv
module mcu_bus_glue
  import mcu_bus_glue_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] addr_i,
  input  logic [7:0]  wdata_i,
  input  logic        rd_i,
  input  logic        wr_i,
  output logic        main_ram_cs_o,
  output logic        scratch_cs_o,
  output logic        rom_cs_o,
  output logic        key_cs_o,
  output logic [5:0]  key_row_o,
  output logic        cfg_sel_o,
  output logic [2:0]  rd_sel_o,
  output logic        spk_o,
  output logic [2:0]  lcd_data_o,
  output logic        lcd_clk_o,
  output logic        irq_clr_o
);
  rd_sel_e rd_sel;
  logic hit_lcd, hit_spk, hit_irqc;

  mcu_bus_glue_decode u_decode (
    .addr_i        (addr_i),
    .main_ram_cs_o (main_ram_cs_o),
    .scratch_cs_o  (scratch_cs_o),
    .rom_cs_o      (rom_cs_o),
    .key_cs_o      (key_cs_o),
    .key_row_o     (key_row_o),
    .cfg_sel_o     (cfg_sel_o),
    .rd_sel_o      (rd_sel),
    .hit_lcd_o     (hit_lcd),
    .hit_spk_o     (hit_spk),
    .hit_irqc_o    (hit_irqc)
  );

  assign rd_sel_o = rd_sel;

  mcu_bus_glue_rdfx u_rdfx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_i       (rd_i),
    .hit_spk_i  (hit_spk),
    .hit_irqc_i (hit_irqc),
    .spk_o      (spk_o),
    .irq_clr_o  (irq_clr_o)
  );

  mcu_bus_glue_lcdfeed #(
    .NUM_LCD (NUM_LCD),
    .DATA_W  (DATA_W),
    .STRIDE  (LCD_BIT_STRIDE)
  ) u_lcdfeed (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .hit_i   (hit_lcd),
    .wdata_i (wdata_i),
    .sdata_o (lcd_data_o),
    .sclk_o  (lcd_clk_o)
  );

  AST_UNMAPPED_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(main_ram_cs_o | scratch_cs_o | rom_cs_o | key_cs_o) |-> (rd_sel_o == 3'd0)); // R5
  AST_KEY_OUTS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_cs_o |-> (key_row_o == 6'd0 && !cfg_sel_o)); // R4
endmodule

// File: tb/mcu_bus_glue_tb_top.sv
module mcu_bus_glue_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic        cs_main, cs_scr, cs_rom, cs_key, cfg_sel, spk, lcd_clk, irq_clr;
  logic [5:0]  key_row;
  logic [2:0]  rd_sel, lcd_data;

  always #5 clk = ~clk;

  mcu_bus_glue dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .rd_i(rd), .wr_i(wr),
    .main_ram_cs_o(cs_main), .scratch_cs_o(cs_scr), .rom_cs_o(cs_rom), .key_cs_o(cs_key),
    .key_row_o(key_row), .cfg_sel_o(cfg_sel), .rd_sel_o(rd_sel), .spk_o(spk),
    .lcd_data_o(lcd_data), .lcd_clk_o(lcd_clk), .irq_clr_o(irq_clr)
  );

  localparam int S_CS = 0, S_RSEL = 1, S_SPK = 2, S_IRQ = 3, S_LCD = 4,
                 S_SCLK = 5, S_ROW = 6, S_CFG = 7;

  typedef struct {
    int         due;
    int         sig;
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  logic spk_model = 1'b0;
  logic [2:0] lcd_model = '0;
  bit done = 1'b0;

  function automatic logic [7:0] observe(int sig);
    case (sig)
      S_CS:   return {4'b0, cs_main, cs_scr, cs_rom, cs_key};
      S_RSEL: return {5'b0, rd_sel};
      S_SPK:  return {7'b0, spk};
      S_IRQ:  return {7'b0, irq_clr};
      S_LCD:  return {5'b0, lcd_data};
      S_SCLK: return {7'b0, lcd_clk};
      S_ROW:  return {2'b0, key_row};
      default: return {7'b0, cfg_sel};
    endcase
  endfunction

  task automatic expect_at(int ahead, int sig, logic [7:0] exp, string req);
    item_t it;
    it.due = cyc + ahead; it.sig = sig; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  // monitor: compare every expected item that falls due this cycle
  always @(posedge clk) begin
    cyc++;
    #2;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due <= cyc) begin
        logic [7:0] act;
        act = observe(q[i].sig);
        checks++;
        if (q[i].due < cyc || act !== q[i].exp) begin
          errors++;
          $display("FAIL %s sig=%0d cyc=%0d actual=%h expected=%h",
                   q[i].req, q[i].sig, cyc, act, q[i].exp);
        end
        q.delete(i);
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd = 1'b0; wr = 1'b0;
    end
  endtask

  // cs vector is {main, scratch, rom, keys}
  task automatic decode_chk(logic [15:0] a, logic [3:0] cs, logic [2:0] rs, string req);
    @(negedge clk);
    addr = a; rd = 1'b0; wr = 1'b0;
    expect_at(1, S_CS, {4'b0, cs}, req);
    expect_at(1, S_RSEL, {5'b0, rs}, req);
  endtask

  task automatic key_chk(logic [15:0] a);
    @(negedge clk);
    addr = a;
    expect_at(1, S_CS, 8'b0001, "R4");
    expect_at(1, S_RSEL, 8'd4, "R4");
    expect_at(1, S_ROW, {2'b0, a[5:0]}, "R4");
    expect_at(1, S_CFG, {7'b0, ~a[6]}, "R4");
  endtask

  // read held for len cycles; one toggle on the first edge only
  task automatic spk_read(int len);
    @(negedge clk);
    addr = 16'h4800; rd = 1'b1;
    spk_model = ~spk_model;
    for (int k = 1; k <= len; k++) expect_at(k, S_SPK, {7'b0, spk_model}, "R7");
    for (int k = 1; k < len; k++) @(negedge clk);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic irq_read(int len);
    @(negedge clk);
    addr = 16'h4C00; rd = 1'b1;
    expect_at(1, S_IRQ, 8'd1, "R8");
    for (int k = 2; k <= len + 1; k++) expect_at(k, S_IRQ, 8'd0, "R8");
    for (int k = 1; k < len; k++) @(negedge clk);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic lcd_write(logic [7:0] d);
    @(negedge clk);
    addr = 16'h4400; wdata = d; wr = 1'b1;
    lcd_model = {d[4], d[2], d[0]};
    expect_at(1, S_LCD, {5'b0, lcd_model}, "R9");
    expect_at(1, S_SCLK, 8'd0, "R10");
    expect_at(2, S_SCLK, 8'd1, "R10");
    expect_at(2, S_LCD, {5'b0, lcd_model}, "R9");
    expect_at(3, S_SCLK, 8'd0, "R10");
    @(negedge clk);
    wr = 1'b0;
    idle(3);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at cyc=%0d actual=hung expected=done", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    expect_at(1, S_SPK, 8'd0, "R7");
    expect_at(1, S_IRQ, 8'd0, "R8");
    expect_at(1, S_LCD, 8'd0, "R9");
    expect_at(1, S_SCLK, 8'd0, "R10");
    idle(2);

    decode_chk(16'h0000, 4'b1000, 3'd1, "R1");
    decode_chk(16'h1234, 4'b1000, 3'd1, "R1");
    decode_chk(16'h3FFF, 4'b1000, 3'd1, "R1");
    decode_chk(16'h5000, 4'b0100, 3'd2, "R2");
    decode_chk(16'h50FF, 4'b0100, 3'd2, "R2");
    decode_chk(16'h8000, 4'b0010, 3'd3, "R3");
    decode_chk(16'hFFFF, 4'b0010, 3'd3, "R3");
    key_chk(16'h4000);
    key_chk(16'h4045);
    key_chk(16'h407F);
    key_chk(16'h401A);
    decode_chk(16'h4080, 4'b0000, 3'd0, "R5");
    decode_chk(16'h5100, 4'b0000, 3'd0, "R5");
    decode_chk(16'h7FFF, 4'b0000, 3'd0, "R5");
    decode_chk(16'h4401, 4'b0000, 3'd0, "R5");
    @(negedge clk);
    expect_at(1, S_ROW, 8'd0, "R4");
    expect_at(1, S_CFG, 8'd0, "R4");
    decode_chk(16'h4400, 4'b0000, 3'd0, "R6");
    decode_chk(16'h4800, 4'b0000, 3'd0, "R6");
    decode_chk(16'h4C00, 4'b0000, 3'd0, "R6");
    idle(1);

    spk_read(1);
    idle(1);
    spk_read(3);
    idle(1);
    spk_read(1);
    idle(1);
    spk_read(2);
    idle(2);

    irq_read(1);
    idle(1);
    irq_read(3);
    idle(2);

    lcd_write(8'h15);
    lcd_write(8'h2A);
    lcd_write(8'h01);
    lcd_write(8'h04);
    lcd_write(8'h10);
    lcd_write(8'hFF);

    // R11: wrong-direction accesses leave side effects alone
    @(negedge clk);
    addr = 16'h4800; wr = 1'b1; wdata = 8'h00;
    expect_at(1, S_SPK, {7'b0, spk_model}, "R11");
    expect_at(2, S_SPK, {7'b0, spk_model}, "R11");
    idle(2);
    @(negedge clk);
    addr = 16'h4C00; wr = 1'b1;
    expect_at(1, S_IRQ, 8'd0, "R11");
    expect_at(2, S_IRQ, 8'd0, "R11");
    idle(2);
    @(negedge clk);
    addr = 16'h4400; rd = 1'b1; wdata = 8'h00;
    expect_at(1, S_LCD, {5'b0, lcd_model}, "R11");
    expect_at(1, S_SCLK, 8'd0, "R11");
    expect_at(2, S_SCLK, 8'd0, "R11");
    expect_at(3, S_LCD, {5'b0, lcd_model}, "R11");
    idle(4);
    // write held several cycles loads once
    @(negedge clk);
    addr = 16'h4400; wr = 1'b1; wdata = 8'h01;
    lcd_model = 3'b001;
    expect_at(2, S_SCLK, 8'd1, "R10");
    expect_at(3, S_SCLK, 8'd0, "R10");
    expect_at(4, S_SCLK, 8'd0, "R10");
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    wr = 1'b0;
    idle(4);

    wait (q.size() == 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule